// File: doc/BRIEF.md
# Multi-Channel Prescaled Countdown Timer

This block holds several independent down-counting timer channels behind a small word-addressed register bus. Each channel has a control word, an initial-count word and a live count word. The channels share one interrupt status word, which holds one bit per channel. A channel counts down once every N reference ticks, where N is its prescaler field plus one. When the count runs out, the channel sets its status bit. In periodic mode it then reloads and keeps going. In one-shot mode it stops and clears its own enable.

The reference tick is a single-cycle enable pulse that arrives on `ref_tick`; the block does not generate it. Software starts a channel by writing the initial count, then writing the control word with the enable bit set. It pauses the channel by clearing enable and resumes it by setting enable again. It acknowledges interrupts by writing ones to the status word. Each channel drives its own interrupt line.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero, every count is zero and every `irq` line is low.
- R2: An enabled channel with prescaler field P decrements its count once every P+1 cycles in which `ref_tick` is high. The prescaler phase restarts from zero whenever the count is reloaded by a bus write, and it holds while the channel is disabled.
- R3: A channel "reaches zero" on a counting step taken while its count is 1 or 0. On that step its bit in the status word (bit i for channel i, word 15) becomes 1.
- R4: On reaching zero, a channel with the periodic bit (control bit 27) set reloads its count from its initial-count word and stays enabled. A channel with bit 27 clear sets its count to 0 and clears its enable bit (control bit 30).
- R5: `irq[i]` is high exactly when the interrupt-enable bit (control bit 29) of channel i and status bit i are both 1. It follows a change of either bit in the cycle after the change is written.
- R6: A write to the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. If a channel reaches zero in the same cycle, its bit ends up set.
- R7: A control write with bit 26 set loads the count from the initial-count word. Bit 26 is never stored and always reads 0.
- R8: A write to a channel's initial-count word (words 5 to 9) also loads that value into the channel's count at once, even while the channel runs.
- R9: While enable is clear the count holds its value. Setting enable without bit 26 resumes counting from that held value.
- R10: Control bit 25 reads as 1 exactly while the channel is enabled, and write data to it is discarded. Only bits 30, 29, 27 and 7:0 (prescaler) are stored; all other written bits are dropped.
- R11: The count words (words 10 to 14) return the live count of channels 0 to 4, and writes to them change nothing.
- R12: Word addresses 0 to 4 hold the control words and 5 to 9 the initial counts. Words 10 to 14 hold the counts and 15 holds the status. A read of any other word returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per tick |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
Directed sequences cover several patterns. A long single-step run at prescaler 0 exposes off-by-one errors in the zero event. A prescaler of 3 with tick bursts that stop mid-phase shows whether the phase is held or lost. A pause followed by a resume tells a frozen count apart from a reload. Random runs vary the prescaler, the initial count, the mode and the tick burst length on random channels. They compare the count, the status bit, the enable bit and the interrupt line with a bench model, and so separate periodic wrap-around from one-shot stop. Separate write patterns check that stray bits are dropped: reserved and read-only control bits, count words, status bits written as zero, and unmapped addresses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned BIT_EN  = 30;
  localparam int unsigned BIT_IE  = 29;
  localparam int unsigned BIT_PER = 27;
  localparam int unsigned BIT_RST = 26;
  localparam int unsigned BIT_ACT = 25;
  localparam int unsigned PSC_MAX_W = 8;

  // Number of reference ticks per counting step.
  function automatic int unsigned f_div_ratio(input logic [PSC_MAX_W-1:0] psc);
    return int'(psc) + 1;
  endfunction

  // A counting step taken at this count is the zero event.
  function automatic logic f_at_zero(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

  // Readback image of a control word.
  function automatic logic [31:0] f_ctrl_word(input logic en, input logic ie,
                                              input logic per,
                                              input logic [PSC_MAX_W-1:0] psc);
    logic [31:0] w;
    w          = '0;
    w[BIT_EN]  = en;
    w[BIT_IE]  = ie;
    w[BIT_PER] = per;
    w[BIT_ACT] = en;
    w[PSC_MAX_W-1:0] = psc;
    return w;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [PSC_W-1:0] limit,
  output logic             step
);

  logic [PSC_W-1:0] phase;

  assign step = adv && (phase >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clr) begin
      phase <= '0;
    end else if (adv) begin
      if (step) phase <= '0;
      else      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             ctrl_we,
  input  logic             reload_we,
  input  logic [31:0]      wdata,
  output logic             en_o,
  output logic             ie_o,
  output logic             per_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);

  logic             en_q, ie_q, per_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             wr_any, restart, adv, step;

  assign wr_any  = ctrl_we || reload_we;
  assign restart = (ctrl_we && wdata[BIT_RST]) || reload_we;
  assign adv     = en_q && ref_tick && !wr_any;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .adv   (adv),
    .limit (psc_q),
    .step  (step)
  );

  assign zero_evt_o = step && f_at_zero(32'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      per_q    <= 1'b0;
      psc_q    <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (ctrl_we) begin
      en_q  <= wdata[BIT_EN];
      ie_q  <= wdata[BIT_IE];
      per_q <= wdata[BIT_PER];
      psc_q <= wdata[PSC_W-1:0];
      if (wdata[BIT_RST]) cnt_q <= reload_q;
    end else if (reload_we) begin
      reload_q <= wdata[CNT_W-1:0];
      cnt_q    <= wdata[CNT_W-1:0];
    end else if (step) begin
      if (zero_evt_o) begin
        if (per_q) begin
          cnt_q <= reload_q;
        end else begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign en_o     = en_q;
  assign ie_o     = ie_q;
  assign per_o    = per_q;
  assign psc_o    = psc_q;
  assign reload_o = reload_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int unsigned NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  input  logic [NCH-1:0] set_mask,
  output logic [NCH-1:0] status
);

  logic [NCH-1:0] keep;

  assign keep = clr_we ? ~clr_mask : {NCH{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & keep) | set_mask;
  end

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NCH-1:0]              en,
  input  logic [NCH-1:0]              ie,
  input  logic [NCH-1:0]              per,
  input  logic [NCH-1:0][PSC_W-1:0]   psc,
  input  logic [NCH-1:0][CNT_W-1:0]   reload,
  input  logic [NCH-1:0][CNT_W-1:0]   cnt,
  input  logic [NCH-1:0]              status,
  output logic [31:0]                 rdata
);

  localparam int unsigned RLD_BASE = NCH;
  localparam int unsigned CNT_BASE = 2 * NCH;
  localparam int unsigned STAT_IDX = 3 * NCH;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(i))
        rdata = f_ctrl_word(en[i], ie[i], per[i], PSC_MAX_W'(psc[i]));
      if (addr == ADDR_W'(RLD_BASE + i))
        rdata = 32'(reload[i]);
      if (addr == ADDR_W'(CNT_BASE + i))
        rdata = 32'(cnt[i]);
    end
    if (addr == ADDR_W'(STAT_IDX))
      rdata = 32'(status);
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int unsigned NCH    = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq
);

  localparam int unsigned RLD_BASE = NCH;
  localparam int unsigned STAT_IDX = 3 * NCH;

  logic [NCH-1:0]            ch_en, ch_ie, ch_per, zero_evt;
  logic [NCH-1:0][PSC_W-1:0] ch_psc;
  logic [NCH-1:0][CNT_W-1:0] ch_reload, ch_cnt;
  logic [NCH-1:0]            status;
  logic                      stat_we;

  assign stat_we = bus_wr && (bus_addr == ADDR_W'(STAT_IDX));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ctrl_we, reload_we;
    assign ctrl_we   = bus_wr && (bus_addr == ADDR_W'(g));
    assign reload_we = bus_wr && (bus_addr == ADDR_W'(RLD_BASE + g));

    tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .ctrl_we    (ctrl_we),
      .reload_we  (reload_we),
      .wdata      (bus_wdata),
      .en_o       (ch_en[g]),
      .ie_o       (ch_ie[g]),
      .per_o      (ch_per[g]),
      .psc_o      (ch_psc[g]),
      .reload_o   (ch_reload[g]),
      .cnt_o      (ch_cnt[g]),
      .zero_evt_o (zero_evt[g])
    );
  end

  tmr_status #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (stat_we),
    .clr_mask (bus_wdata[NCH-1:0]),
    .set_mask (zero_evt),
    .status   (status)
  );

  tmr_rdmux #(.NCH(NCH), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_rd (
    .addr   (bus_addr),
    .en     (ch_en),
    .ie     (ch_ie),
    .per    (ch_per),
    .psc    (ch_psc),
    .reload (ch_reload),
    .cnt    (ch_cnt),
    .status (status),
    .rdata  (bus_rdata)
  );

  assign irq = ch_ie & status;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0]            ch_en,
  input logic [NCH-1:0]            ch_ie,
  input logic [NCH-1:0]            ch_per,
  input logic [NCH-1:0]            zero_evt,
  input logic [NCH-1:0][CNT_W-1:0] ch_reload,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0]            status
);

  localparam int unsigned STAT_IDX = 3 * NCH;

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_status_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt[i] |=> status[i]);

    p_periodic_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt[i] && ch_per[i] && !bus_wr |=> ch_cnt[i] == $past(ch_reload[i]) && ch_en[i]);

    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt[i] && !ch_per[i] && !bus_wr |=> !ch_en[i] && ch_cnt[i] == '0);

    p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt[i] && ch_ie[i] && !bus_wr |=> irq[i]);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(STAT_IDX) && bus_wdata[i] && !zero_evt[i] |=> !status[i]);

    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] && !bus_wr |=> $stable(ch_cnt[i]));
  end

  p_rst_bit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr < ADDR_W'(NCH) |-> !bus_rdata[BIT_RST]);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr > ADDR_W'(STAT_IDX) |-> bus_rdata == 32'd0);

endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ch_en     (ch_en),
  .ch_ie     (ch_ie),
  .ch_per    (ch_per),
  .zero_evt  (zero_evt),
  .ch_reload (ch_reload),
  .ch_cnt    (ch_cnt),
  .status    (status)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;

  localparam int NCH = 5;
  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] IE  = 32'h2000_0000;
  localparam logic [31:0] PER = 32'h0800_0000;
  localparam logic [31:0] RST = 32'h0400_0000;
  localparam logic [31:0] ACT = 32'h0200_0000;
  localparam int STAT = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int a_ctrl(input int c); return c; endfunction
  function automatic int a_rld(input int c);  return 5 + c; endfunction
  function automatic int a_cnt(input int c);  return 10 + c; endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bwr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic brd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a);
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  // Bench model of one channel started fresh from its initial count.
  function automatic void model(input int rl, input int psc, input bit per, input int n,
                                output int cnt, output bit fired, output bit en);
    int phase = 0;
    cnt = rl; fired = 0; en = 1;
    for (int k = 0; k < n; k++) begin
      if (!en) break;
      if (phase >= psc) begin
        phase = 0;
        if (cnt <= 1) begin
          fired = 1;
          if (per) cnt = rl;
          else begin cnt = 0; en = 0; end
        end else cnt--;
      end else phase++;
    end
  endfunction

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int ecnt; bit efired, een;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      brd(a, d); chk(d, 32'd0, $sformatf("R1 word %0d", a));
    end
    chk(32'(irq), 32'd0, "R1 irq");

    // R12: unmapped reads
    brd(16, d); chk(d, 0, "R12 word 16");
    brd(63, d); chk(d, 0, "R12 word 63");

    // R9: pause and resume, prescaler 0
    bwr(a_rld(0), 100);
    bwr(a_ctrl(0), EN | RST);
    ticks(10);
    brd(a_cnt(0), d); chk(d, 90, "R9 running count");
    bwr(a_ctrl(0), 0);
    ticks(10);
    brd(a_cnt(0), d); chk(d, 90, "R9 frozen count");
    brd(a_ctrl(0), d); chk(d, 0, "R10 active clear when paused");
    bwr(a_ctrl(0), EN);
    brd(a_ctrl(0), d); chk(d, EN | ACT, "R10 active while enabled");
    ticks(5);
    brd(a_cnt(0), d); chk(d, 85, "R9 resumed count");
    bwr(a_ctrl(0), 0);

    // R2: prescaler 3 with phase held across bursts
    bwr(a_rld(1), 50);
    bwr(a_ctrl(1), EN | RST | 3);
    ticks(12);
    brd(a_cnt(1), d); chk(d, 47, "R2 12 ticks div 4");
    ticks(3);
    brd(a_cnt(1), d); chk(d, 47, "R2 mid phase");
    ticks(1);
    brd(a_cnt(1), d); chk(d, 46, "R2 phase complete");

    // R8: reload write while running
    bwr(a_rld(1), 200);
    brd(a_cnt(1), d); chk(d, 200, "R8 immediate load");
    ticks(4);
    brd(a_cnt(1), d); chk(d, 199, "R8 counts from new value");
    bwr(a_ctrl(1), 0);

    // R4/R3: periodic wrap
    bwr(a_rld(2), 3);
    bwr(a_ctrl(2), EN | PER | RST);
    ticks(7);
    brd(a_cnt(2), d); chk(d, 2, "R4 periodic wrap count");
    brd(a_ctrl(2), d); chk(d, EN | PER | ACT, "R4 periodic stays enabled");
    // R4/R5: one-shot stop with interrupt
    bwr(a_rld(3), 3);
    bwr(a_ctrl(3), EN | IE | RST);
    ticks(5);
    brd(a_cnt(3), d); chk(d, 0, "R4 one-shot count");
    brd(a_ctrl(3), d); chk(d, IE, "R4 one-shot cleared enable");
    brd(STAT, d); chk(d, 32'b01100, "R3 status bits");
    chk(32'(irq), 32'b01000, "R5 irq one-shot");

    // R6: write-one-to-clear
    bwr(a_ctrl(2), 0);
    bwr(STAT, 32'b00100);
    brd(STAT, d); chk(d, 32'b01000, "R6 partial clear");
    chk(32'(irq), 32'b01000, "R6 irq kept");
    bwr(STAT, 32'b01000);
    brd(STAT, d); chk(d, 0, "R6 full clear");
    chk(32'(irq), 0, "R5 irq dropped after clear");

    // R5: interrupt enable gating
    bwr(a_rld(4), 1);
    bwr(a_ctrl(4), EN | RST);
    ticks(1);
    brd(STAT, d); chk(d, 32'b10000, "R3 reload 1 fires");
    chk(32'(irq), 0, "R5 masked");
    bwr(a_ctrl(4), IE);
    #1 chk(32'(irq), 32'b10000, "R5 unmasked");
    bwr(a_ctrl(4), 0);
    #1 chk(32'(irq), 0, "R5 masked again");
    bwr(STAT, 32'h1f);

    // R7: counter reset bit
    bwr(a_ctrl(0), RST);
    brd(a_cnt(0), d); chk(d, 100, "R7 reload on reset bit");
    brd(a_ctrl(0), d); chk(d, 0, "R7 reset bit reads zero");

    // R10: reserved and active bits dropped
    bwr(a_ctrl(0), 32'hBFFF_FFFF);
    brd(a_ctrl(0), d); chk(d, IE | PER | 32'hFF, "R10 reserved dropped");
    bwr(a_ctrl(0), 0);

    // R11: count word is read-only
    bwr(a_cnt(0), 32'd1234);
    brd(a_cnt(0), d); chk(d, 100, "R11 count write ignored");

    // R12: write to unmapped word changes nothing
    bwr(20, 32'hFFFF_FFFF);
    brd(a_rld(0), d); chk(d, 100, "R12 unmapped write");
    brd(a_ctrl(0), d); chk(d, 0, "R12 ctrl untouched");

    // R2/R3/R4: random runs
    for (int it = 0; it < 14; it++) begin
      int ch = $urandom_range(0, 4);
      int psc = $urandom_range(0, 3);
      int rl = $urandom_range(1, 12);
      bit per = 1'($urandom_range(0, 1));
      int n = $urandom_range(1, 40);
      model(rl, psc, per, n, ecnt, efired, een);
      bwr(a_ctrl(ch), 0);
      bwr(STAT, 32'h1f);
      bwr(a_rld(ch), 32'(rl));
      bwr(a_ctrl(ch), EN | IE | RST | (per ? PER : 0) | 32'(psc));
      ticks(n);
      brd(a_cnt(ch), d); chk(d, 32'(ecnt), $sformatf("R2 random count it%0d", it));
      brd(STAT, d); chk(32'(d[ch]), 32'(efired), $sformatf("R3 random status it%0d", it));
      chk(32'(irq[ch]), 32'(efired), $sformatf("R5 random irq it%0d", it));
      brd(a_ctrl(ch), d); chk(32'(d[30]), 32'(een), $sformatf("R4 random enable it%0d", it));
      bwr(a_ctrl(ch), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule